// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block brings the contacts of a contact smart card up and down in a fixed order. A host opens a session by driving an active-low command line from high to low while a card is present. The block first turns on the card supply. Once an external supply-good flag reports the supply at level, it opens the I/O lines, then starts the card clock, and finally hands the card reset line over to the host. Every step delay is a parameter counted in system clock cycles.

The level of the host reset input, sampled when the session starts, picks one of two activation modes. In normal mode the clock starts on a fixed delay after the I/O lines open. In host-clock mode the clock starts on the first falling edge of the host reset input. The card reset is held low for a fixed window and only then follows the host reset. This lets the host count card clock cycles exactly before it requests an answer to reset.

The session closes when the command returns high. A card removal or a fault (overload, overtemperature or undervoltage, combined by the caller into one flag) closes it at once, even partway through activation. Teardown runs the contacts down in reverse order with fixed gaps between steps. The block returns to idle only after the supply has been switched off. Analog regulation and level shifting live outside this block.

Top module: `sc_activation_seq`

## Requirements
- R1: A session starts only when `cmd_n` is sampled high on one clock edge and low on the next, with `card_present` high and the block idle. `vcc_en` rises after that second edge. A command that is already low when reset ends, or a toggle made without a card, starts nothing.
- R2: While `vcc_en` is high and `supply_good` has not yet been sampled high, `io_en`, `clk_en` and `card_rst` stay low.
- R3: In normal mode (`host_rst` low on the start edge), `io_en` rises after the edge that samples `supply_good` high. `clk_en` rises IO_TO_CLK cycles after that. The reset path opens CLK_TO_RST cycles later, and from then on `card_rst` equals `host_rst` with no register delay.
- R4: In host-clock mode (`host_rst` high on the start edge), `clk_en` rises after the first edge that sees `host_rst` go from high to low while the I/O lines are open. If no such fall arrives, the clock starts when the reset window ends.
- R5: In host-clock mode, `card_rst` stays low until RST_WINDOW cycles after `io_en` rose. After that it equals `host_rst`, and `host_rst` no longer affects `clk_en`.
- R6: When `cmd_n` is sampled high during a session, teardown starts and `in_session` drops. `card_rst` goes low at once. `clk_en` drops RST_TO_CLK cycles later, `io_en` drops CLK_TO_IO cycles after that, and `vcc_en` drops IO_TO_VCC cycles after that, which returns the block to idle.
- R7: `card_present` low or `fault` high, sampled during activation or during a session, starts the same teardown on that edge and sets `fault_stop`. `fault_stop` stays high until the next session starts. A teardown caused only by the command leaves `fault_stop` low.
- R8: A teardown only steps down the enables that were on. After an abort while the supply is still ramping, `io_en` and `clk_en` stay low throughout the teardown.
- R9: A command held low through and after a teardown does not start a new session. The command must go high and then low again.
- R10: While reset is held and after it is released, all outputs are low until a session starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Host session command, active low |
| host_rst | input | 1 | Host reset input toward the card |
| card_present | input | 1 | Debounced card presence, high when a card is inserted |
| supply_good | input | 1 | Card supply has reached its level |
| fault | input | 1 | Combined overload, overtemperature and undervoltage flag |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O lines enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset level |
| in_session | output | 1 | Activation running or session open |
| fault_stop | output | 1 | Last session ended through removal or fault |

## Verification
Directed runs walk through a normal activation and both ways of starting the clock in host-clock mode: on a falling edge of `host_rst`, and at the end of the window when no fall arrives. These runs separate the fixed-delay clock start from the host-timed one, and show where reset control is handed to the host. Further runs abort while the supply ramps and fault during an open session. These show that teardown skips enables that were never raised, and that only a removal or a fault sets `fault_stop`. Seeded random traffic on all inputs is then compared cycle by cycle against a reference model in the bench. This exposes mistakes in edge detection, in the re-arm rule and in the order of teardown that the fixed scenarios do not reach.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_RAMP = 4'd1,
    S_IO   = 4'd2,
    S_CLK  = 4'd3,
    S_HCLK = 4'd4,
    S_ON   = 4'd5,
    S_DRST = 4'd6,
    S_DCLK = 4'd7,
    S_DIO  = 4'd8
  } seq_state_e;

  function automatic logic is_activating(seq_state_e s);
    return (s == S_RAMP) || (s == S_IO) || (s == S_CLK) ||
           (s == S_HCLK) || (s == S_ON);
  endfunction

  function automatic int unsigned max6(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d,
                                       int unsigned e, int unsigned f);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return m;
  endfunction
endpackage

// File: rtl/sc_step_timer.sv
module sc_step_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // A count sits at zero once it is loaded with zero, and it never wraps below zero.
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_seq_pkg::*;
#(
  parameter int IO_TO_CLK  = 25,
  parameter int CLK_TO_RST = 25,
  parameter int RST_WINDOW = 10000,
  parameter int RST_TO_CLK = 600,
  parameter int CLK_TO_IO  = 600,
  parameter int IO_TO_VCC  = 600,
  parameter int TW         = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_n,
  input  logic          host_rst,
  input  logic          card_present,
  input  logic          supply_good,
  input  logic          fault,
  input  logic          t_zero,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output seq_state_e    state,
  output logic          fault_stop
);
  localparam logic [TW-1:0] L_IO_CLK  = TW'(IO_TO_CLK - 1);
  localparam logic [TW-1:0] L_CLK_RST = TW'(CLK_TO_RST - 1);
  localparam logic [TW-1:0] L_WINDOW  = TW'(RST_WINDOW - 1);
  localparam logic [TW-1:0] L_RST_CLK = TW'(RST_TO_CLK - 1);
  localparam logic [TW-1:0] L_CLK_IO  = TW'(CLK_TO_IO - 1);
  localparam logic [TW-1:0] L_IO_VCC  = TW'(IO_TO_VCC - 1);

  seq_state_e state_d;
  logic cmd_q, host_q, host_mode;
  logic start, abort, bad_card, host_fall;

  assign bad_card  = !card_present || fault;
  assign abort     = cmd_n || bad_card;
  assign start     = (state == S_IDLE) && cmd_q && !cmd_n && card_present;
  assign host_fall = host_q && !host_rst;

  always_comb begin
    state_d = state;
    t_load  = 1'b0;
    t_val   = '0;
    if (is_activating(state) && abort) begin
      state_d = S_DRST;
      t_load  = 1'b1;
      t_val   = L_RST_CLK;
    end else begin
      unique case (state)
        S_IDLE: if (start) state_d = S_RAMP;
        S_RAMP: if (supply_good) begin
          state_d = S_IO;
          t_load  = 1'b1;
          t_val   = host_mode ? L_WINDOW : L_IO_CLK;
        end
        S_IO: begin
          if (host_mode) begin
            if (t_zero)         state_d = S_ON;
            else if (host_fall) state_d = S_HCLK;
          end else if (t_zero) begin
            state_d = S_CLK;
            t_load  = 1'b1;
            t_val   = L_CLK_RST;
          end
        end
        S_CLK:  if (t_zero) state_d = S_ON;
        S_HCLK: if (t_zero) state_d = S_ON;
        S_ON:   state_d = S_ON;
        S_DRST: if (t_zero) begin
          state_d = S_DCLK;
          t_load  = 1'b1;
          t_val   = L_CLK_IO;
        end
        S_DCLK: if (t_zero) begin
          state_d = S_DIO;
          t_load  = 1'b1;
          t_val   = L_IO_VCC;
        end
        S_DIO:  if (t_zero) state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cmd_q      <= 1'b0;
      host_q     <= 1'b0;
      host_mode  <= 1'b0;
      fault_stop <= 1'b0;
    end else begin
      state  <= state_d;
      cmd_q  <= cmd_n;
      host_q <= host_rst;
      if (start) begin
        host_mode  <= host_rst;
        fault_stop <= 1'b0;
      end else if (is_activating(state) && bad_card) begin
        fault_stop <= 1'b1;
      end
    end
  end

  // R7: a removal or a fault during activation or a session goes straight to teardown.
  p_fault_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_activating(state) && bad_card) |=> (state == S_DRST && fault_stop));

  // R6: a teardown never returns to an activation state before it reaches idle.
  p_teardown_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRST || state == S_DCLK || state == S_DIO) |=> !is_activating(state));
endmodule

// File: rtl/sc_contact_drive.sv
module sc_contact_drive
  import sc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state,
  input  logic       host_rst,
  output logic       vcc_en,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       in_session
);
  logic io_live, clk_live, io_ran, clk_ran;

  assign io_live  = state inside {S_IO, S_CLK, S_HCLK, S_ON};
  assign clk_live = state inside {S_CLK, S_HCLK, S_ON};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_ran  <= 1'b0;
      clk_ran <= 1'b0;
    end else if (state == S_IDLE) begin
      io_ran  <= 1'b0;
      clk_ran <= 1'b0;
    end else begin
      if (io_live)  io_ran  <= 1'b1;
      if (clk_live) clk_ran <= 1'b1;
    end
  end

  assign vcc_en     = (state != S_IDLE);
  assign io_en      = io_live || ((state == S_DRST || state == S_DCLK) && io_ran);
  assign clk_en     = clk_live || ((state == S_DRST) && clk_ran);
  assign card_rst   = (state == S_ON) && host_rst;
  assign in_session = is_activating(state);

  // R2/R3: each contact only runs while the one it depends on is up.
  p_io_needs_vcc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);
  p_clk_needs_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);
  p_rst_needs_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> clk_en);
endmodule

// File: rtl/sc_activation_seq.sv
module sc_activation_seq
  import sc_seq_pkg::*;
#(
  parameter int IO_TO_CLK  = 25,
  parameter int CLK_TO_RST = 25,
  parameter int RST_WINDOW = 10000,
  parameter int RST_TO_CLK = 600,
  parameter int CLK_TO_IO  = 600,
  parameter int IO_TO_VCC  = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic host_rst,
  input  logic card_present,
  input  logic supply_good,
  input  logic fault,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic in_session,
  output logic fault_stop
);
  localparam int unsigned LONGEST = max6(IO_TO_CLK, CLK_TO_RST, RST_WINDOW,
                                         RST_TO_CLK, CLK_TO_IO, IO_TO_VCC);
  localparam int TW = $clog2(LONGEST) + 1;

  seq_state_e    state;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;

  sc_step_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  sc_seq_fsm #(
    .IO_TO_CLK(IO_TO_CLK), .CLK_TO_RST(CLK_TO_RST), .RST_WINDOW(RST_WINDOW),
    .RST_TO_CLK(RST_TO_CLK), .CLK_TO_IO(CLK_TO_IO), .IO_TO_VCC(IO_TO_VCC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
    .card_present(card_present), .supply_good(supply_good), .fault(fault),
    .t_zero(t_zero), .t_load(t_load), .t_val(t_val), .state(state),
    .fault_stop(fault_stop)
  );

  sc_contact_drive u_drive (
    .clk(clk), .rst_n(rst_n), .state(state), .host_rst(host_rst),
    .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst),
    .in_session(in_session)
  );

  // R1: the supply turns on only after a high-to-low command with a card present.
  p_start_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> ($past(!cmd_n) && $past(cmd_n, 2) && $past(card_present)));

  // R6: the supply goes off only after the I/O lines are already off.
  p_vcc_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> $past(!io_en));
endmodule

// File: tb/sim_sc_activation_seq.sv
module sim_sc_activation_seq;
  localparam int P_IO_CLK = 3, P_CLK_RST = 4, P_WIN = 20;
  localparam int P_RST_CLK = 5, P_CLK_IO = 3, P_IO_VCC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_n = 1'b1, host_rst = 1'b0, card_present = 1'b0;
  logic supply_good = 1'b0, fault = 1'b0;
  logic vcc_en, io_en, clk_en, card_rst, in_session, fault_stop;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sc_activation_seq #(
    .IO_TO_CLK(P_IO_CLK), .CLK_TO_RST(P_CLK_RST), .RST_WINDOW(P_WIN),
    .RST_TO_CLK(P_RST_CLK), .CLK_TO_IO(P_CLK_IO), .IO_TO_VCC(P_IO_VCC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
    .card_present(card_present), .supply_good(supply_good), .fault(fault),
    .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst),
    .in_session(in_session), .fault_stop(fault_stop)
  );

  // Reference model; phases: 0 idle, 1 ramp, 2 io, 3 clk, 4 host clk, 5 on, 6-8 teardown.
  int m_ph = 0, m_cnt = 0;
  bit m_host = 0, m_fstop = 0, m_cmd_q = 0, m_hq = 0, m_ioran = 0, m_clkran = 0;

  task automatic model_step();
    int ph;
    bit act, ld;
    ph  = m_ph;
    act = (ph >= 1 && ph <= 5);
    ld  = 0;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_host = 0; m_fstop = 0; m_cmd_q = 0; m_hq = 0;
      m_ioran = 0; m_clkran = 0;
      return;
    end
    if (act && (cmd_n || !card_present || fault)) begin
      m_ph = 6; m_cnt = P_RST_CLK - 1; ld = 1;
      if (!card_present || fault) m_fstop = 1;
    end else begin
      case (ph)
        0: if (m_cmd_q && !cmd_n && card_present) begin
             m_ph = 1; m_host = host_rst; m_fstop = 0;
           end
        1: if (supply_good) begin
             m_ph = 2; ld = 1; m_cnt = m_host ? P_WIN - 1 : P_IO_CLK - 1;
           end
        2: if (m_host) begin
             if (m_cnt == 0) m_ph = 5;
             else if (m_hq && !host_rst) m_ph = 4;
           end else if (m_cnt == 0) begin
             m_ph = 3; ld = 1; m_cnt = P_CLK_RST - 1;
           end
        3, 4: if (m_cnt == 0) m_ph = 5;
        6: if (m_cnt == 0) begin m_ph = 7; ld = 1; m_cnt = P_CLK_IO - 1; end
        7: if (m_cnt == 0) begin m_ph = 8; ld = 1; m_cnt = P_IO_VCC - 1; end
        8: if (m_cnt == 0) m_ph = 0;
        default: ;
      endcase
    end
    if (!ld && m_cnt != 0) m_cnt--;
    if (ph == 0) begin m_ioran = 0; m_clkran = 0; end
    else begin
      if (ph >= 2 && ph <= 5) m_ioran = 1;
      if (ph >= 3 && ph <= 5) m_clkran = 1;
    end
    m_cmd_q = cmd_n;
    m_hq    = host_rst;
  endtask

  function automatic logic [5:0] expected();
    logic [5:0] e;
    e[5] = (m_ph != 0);
    e[4] = (m_ph >= 2 && m_ph <= 5) || ((m_ph == 6 || m_ph == 7) && m_ioran);
    e[3] = (m_ph >= 3 && m_ph <= 5) || (m_ph == 6 && m_clkran);
    e[2] = (m_ph == 5) && host_rst;
    e[1] = (m_ph >= 1 && m_ph <= 5);
    e[0] = m_fstop;
    return e;
  endfunction

  function automatic string tag_of();
    if (m_fstop && m_ph != 0) return "R7";
    case (m_ph)
      0: return "R1";
      1: return "R2";
      2, 3: return m_host ? "R4" : "R3";
      4: return "R4";
      5: return m_host ? "R5" : "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {vcc_en, io_en, clk_en, card_rst, in_session, fault_stop};
  endfunction

  bit io_seen = 0;

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (io_en || clk_en) io_seen = 1;
    check(tag_of(), outs(), expected());
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic single_check(string tag, logic act, logic exp);
    check(tag, {5'd0, act}, {5'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7531));
    run(3);
    check("R10", outs(), 6'd0);
    rst_n = 1'b1;
    cmd_n = 1'b0; card_present = 1'b1;
    run(8);
    single_check("R1", vcc_en, 1'b0);
    // toggle with no card
    cmd_n = 1'b1; card_present = 1'b0; run(2);
    cmd_n = 1'b0; run(4);
    single_check("R1", vcc_en, 1'b0);
    cmd_n = 1'b1; card_present = 1'b1; run(2);
    // normal activation then command teardown
    host_rst = 1'b0; cmd_n = 1'b0; run(5);
    supply_good = 1'b1; run(P_IO_CLK + P_CLK_RST + 3);
    host_rst = 1'b1; run(2);
    single_check("R3", card_rst, 1'b1);
    cmd_n = 1'b1; run(P_RST_CLK + P_CLK_IO + P_IO_VCC + 3);
    single_check("R7", fault_stop, 1'b0);
    // host-clock mode with a falling edge
    supply_good = 1'b0; host_rst = 1'b1; cmd_n = 1'b0; run(3);
    supply_good = 1'b1; run(4);
    single_check("R4", clk_en, 1'b0);
    host_rst = 1'b0; run(2);
    single_check("R4", clk_en, 1'b1);
    host_rst = 1'b1; run(3);
    single_check("R5", card_rst, 1'b0);
    run(P_WIN);
    single_check("R5", card_rst, 1'b1);
    // fault in session, command held low through teardown
    fault = 1'b1; cyc(); fault = 1'b0;
    run(P_RST_CLK + P_CLK_IO + P_IO_VCC + 6);
    single_check("R7", fault_stop, 1'b1);
    single_check("R9", vcc_en, 1'b0);
    // host mode without a fall: clock at window end
    cmd_n = 1'b1; run(2);
    supply_good = 1'b0; host_rst = 1'b1; cmd_n = 1'b0; run(2);
    supply_good = 1'b1; run(P_WIN + 2);
    single_check("R4", clk_en, 1'b1);
    cmd_n = 1'b1; run(P_RST_CLK + P_CLK_IO + P_IO_VCC + 3);
    // abort during ramp
    supply_good = 1'b0; host_rst = 1'b0; cmd_n = 1'b0; run(3);
    io_seen = 0; card_present = 1'b0; run(P_RST_CLK + P_CLK_IO + P_IO_VCC + 3);
    single_check("R8", io_seen, 1'b0);
    single_check("R8", vcc_en, 1'b0);
    card_present = 1'b1; cmd_n = 1'b1; run(2);
    // seeded random traffic checked against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 99) < 6)  cmd_n = ~cmd_n;
      if ($urandom_range(0, 99) < 8)  host_rst = ~host_rst;
      if ($urandom_range(0, 99) < 10) supply_good = ~supply_good;
      card_present = ($urandom_range(0, 199) != 0);
      fault = ($urandom_range(0, 299) == 0);
      cyc();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule